// File: doc/BRIEF.md
# Shared Wired-OR Interrupt Source Group

This block holds the interrupt logic of several peripheral sources that share the processor's interrupt lines. Each source latches an event into a pending flag. The flag stays set until the handler acknowledges it. Each source also has an enable flag and a two-bit priority level. A source that is pending, enabled and set to a nonzero level pulls on the shared request. The request is modelled as an open-drain, wired-OR line.

A resolver merges the contributions of all sources. It presents the highest requested level on three active-low lines. Level 0 means that no interrupt is requested.

The handler reads a per-source status word to find out which source raised the request. It acknowledges a source by writing a one to that source's bit in a clear mask. Clearing one source releases only that source's contribution. The line stays asserted while any other source is still driving it.

Top module: `shirq_top`

## Requirements
- R1: After reset, every pending, enable and level field is 0, `src_active_o` is all zeros and `irq_n_o` is 3'b111.
- R2: A source's pending flag is set in the clock after its event input goes from 0 to 1. An event input that is held high does not set the flag again after the flag has been cleared.
- R3: Writing the clear mask with `clr_we_i` = 1 clears the pending flag of every source whose mask bit is 1. Sources whose mask bit is 0 are left unchanged.
- R4: When an event rising edge and a clear of the same source fall in the same clock, the pending flag ends up set.
- R5: A source drives the request (`src_active_o` bit = 1) only when it is pending and enabled and its level is nonzero.
- R6: Level value 0 stops the source from driving even when it is pending and enabled. Values 1, 2 and 3 select the level that the source requests.
- R7: `irq_n_o` is the bitwise inverse of the highest level requested by any driving source, zero-extended to 3 bits. For example, level 2 gives 3'b101 and level 3 gives 3'b100. When no source drives, `irq_n_o` is 3'b111.
- R8: When several sources request the same level, the line stays at that level until the last of those sources is cleared.
- R9: `rd_status_o` for source `rd_idx_i` is {level[3:2], enable[1], pending[0]}. Reading it has no side effect on any state.
- R10: A disabled source still records events as pending. Enabling it later makes it drive at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | N | Event input of each source |
| cfg_we_i | input | 1 | Write enable and level of one source |
| cfg_idx_i | input | IDX_W | Source selected for the configuration write |
| cfg_en_i | input | 1 | Enable value to write |
| cfg_lvl_i | input | 2 | Level value to write |
| clr_we_i | input | 1 | Apply the clear mask |
| clr_mask_i | input | N | One bit per source; a 1 clears that source's pending flag |
| rd_idx_i | input | IDX_W | Source selected for the status read |
| rd_status_o | output | 4 | {level, enable, pending} of the selected source |
| src_active_o | output | N | Per-source open-drain drive flags |
| irq_n_o | output | 3 | Active-low encoded highest requested level |

## Verification
An event edge and a handler clear can land on the same source in the same clock. The bench provokes this by raising an event while it writes that source's clear bit. It then expects the source to stay pending and to keep driving its level.

A second collision happens on the shared line. Two sources at one level are made pending, and then only one of them is cleared. The behavioural model predicts that the line stays asserted until the second clear. The bench compares the model with the outputs on every clock.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
  localparam int LVL_W  = 2;
  localparam int CODE_W = 3;
  localparam int STAT_W = LVL_W + 2;

  typedef logic [LVL_W-1:0] lvl_t;

  // Larger of two levels
  function automatic lvl_t lvl_max(lvl_t a, lvl_t b);
    return (a > b) ? a : b;
  endfunction

  // Active-low encoding of a level on the request lines
  function automatic logic [CODE_W-1:0] lvl_to_code_n(lvl_t l);
    return ~{{(CODE_W-LVL_W){1'b0}}, l};
  endfunction

  // Status word packing: level, enable, pending
  function automatic logic [STAT_W-1:0] pack_status(lvl_t l, logic en, logic pend);
    return {l, en, pend};
  endfunction
endpackage

// File: rtl/shirq_src.sv
module shirq_src
  import shirq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic cfg_we_i,
  input  logic cfg_en_i,
  input  lvl_t cfg_lvl_i,
  output logic pend_o,
  output logic en_o,
  output lvl_t lvl_o,
  output logic rise_o,
  output logic drive_o,
  output lvl_t req_lvl_o
);
  logic evt_q;
  logic pend_q;
  logic en_q;
  lvl_t lvl_q;

  assign rise_o = evt_i & ~evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= 1'b0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      lvl_q  <= '0;
    end else begin
      evt_q <= evt_i;
      if (rise_o)     pend_q <= 1'b1;   // set has priority over clear
      else if (clr_i) pend_q <= 1'b0;
      if (cfg_we_i) begin
        en_q  <= cfg_en_i;
        lvl_q <= cfg_lvl_i;
      end
    end
  end

  assign drive_o   = pend_q & en_q & (lvl_q != '0);
  assign req_lvl_o = drive_o ? lvl_q : '0;
  assign pend_o    = pend_q;
  assign en_o      = en_q;
  assign lvl_o     = lvl_q;
endmodule

// File: rtl/shirq_resolver.sv
module shirq_resolver
  import shirq_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N*LVL_W-1:0] req_lvl_i,
  output logic [CODE_W-1:0]  irq_n_o
);
  lvl_t acc [N+1];

  assign acc[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign acc[i+1] = lvl_max(acc[i], req_lvl_i[i*LVL_W +: LVL_W]);
  end

  assign irq_n_o = lvl_to_code_n(acc[N]);
endmodule

// File: rtl/shirq_top.sv
module shirq_top
  import shirq_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      evt_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_en_i,
  input  logic [1:0]        cfg_lvl_i,
  input  logic              clr_we_i,
  input  logic [N-1:0]      clr_mask_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [3:0]        rd_status_o,
  output logic [N-1:0]      src_active_o,
  output logic [2:0]        irq_n_o
);
  logic [N-1:0]       evt_rise;
  logic [N-1:0]       clr_hit;
  logic [N-1:0]       pend_vec;
  logic [N-1:0]       en_vec;
  logic [N*LVL_W-1:0] lvl_vec;
  logic [N*LVL_W-1:0] req_lvl_vec;

  assign clr_hit = clr_we_i ? clr_mask_i : '0;

  for (genvar i = 0; i < N; i++) begin : g_src
    lvl_t lvl_w;
    lvl_t req_w;
    shirq_src u_src (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i[i]),
      .clr_i     (clr_hit[i]),
      .cfg_we_i  (cfg_we_i && (cfg_idx_i == IDX_W'(i))),
      .cfg_en_i  (cfg_en_i),
      .cfg_lvl_i (cfg_lvl_i),
      .pend_o    (pend_vec[i]),
      .en_o      (en_vec[i]),
      .lvl_o     (lvl_w),
      .rise_o    (evt_rise[i]),
      .drive_o   (src_active_o[i]),
      .req_lvl_o (req_w)
    );
    assign lvl_vec[i*LVL_W +: LVL_W]     = lvl_w;
    assign req_lvl_vec[i*LVL_W +: LVL_W] = req_w;
  end

  shirq_resolver #(.N(N)) u_res (
    .req_lvl_i (req_lvl_vec),
    .irq_n_o   (irq_n_o)
  );

  always_comb begin
    rd_status_o = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_idx_i == IDX_W'(i))
        rd_status_o = pack_status(lvl_vec[i*LVL_W +: LVL_W], en_vec[i], pend_vec[i]);
    end
  end
endmodule

// File: rtl/shirq_chk.sv
module shirq_chk #(
  parameter int N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clr_we_i,
  input logic [N-1:0] evt_rise,
  input logic [N-1:0] clr_hit,
  input logic [N-1:0] pend_vec,
  input logic [N-1:0] en_vec,
  input logic [N-1:0] src_active_o,
  input logic [2:0]   irq_n_o
);
  a_r2_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_rise) |=> ((pend_vec & $past(evt_rise)) == $past(evt_rise)));

  a_r3_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((pend_vec & $past(clr_hit & ~evt_rise)) == '0));

  a_r3_fall_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend_vec) |=> ((~pend_vec & $past(pend_vec) & ~$past(clr_hit)) == '0));

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_rise & clr_hit)) |=> ((pend_vec & $past(evt_rise & clr_hit)) == $past(evt_rise & clr_hit)));

  a_r5_drive_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_active_o & ~(pend_vec & en_vec)) == '0));

  a_r7_idle_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_active_o == '0) == (irq_n_o == 3'b111)));
endmodule

bind shirq_top shirq_chk #(.N(N)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clr_we_i     (clr_we_i),
  .evt_rise     (evt_rise),
  .clr_hit      (clr_hit),
  .pend_vec     (pend_vec),
  .en_vec       (en_vec),
  .src_active_o (src_active_o),
  .irq_n_o      (irq_n_o)
);

// File: tb/shirq_top_tb.sv
`timescale 1ns/1ps
module shirq_top_tb;
  localparam int N = 4;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic cfg_we = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic cfg_en = 1'b0;
  logic [1:0] cfg_lvl = '0;
  logic clr_we = 1'b0;
  logic [N-1:0] clr_mask = '0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic [3:0] rd_status;
  logic [N-1:0] src_active;
  logic [2:0] irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shirq_top #(.N(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_en_i(cfg_en), .cfg_lvl_i(cfg_lvl),
    .clr_we_i(clr_we), .clr_mask_i(clr_mask), .rd_idx_i(rd_idx),
    .rd_status_o(rd_status), .src_active_o(src_active), .irq_n_o(irq_n)
  );

  // Behavioural reference model
  bit m_pend [N];
  bit m_en   [N];
  int m_lvl  [N];
  bit m_prev [N];

  initial for (int i = 0; i < N; i++) begin
    m_pend[i] = 0; m_en[i] = 0; m_lvl[i] = 0; m_prev[i] = 0;
  end

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        m_pend[i] = 0; m_en[i] = 0; m_lvl[i] = 0; m_prev[i] = 0;
      end else begin
        if (evt[i] && !m_prev[i]) m_pend[i] = 1;
        else if (clr_we && clr_mask[i]) m_pend[i] = 0;
        if (cfg_we && cfg_idx == i) begin
          m_en[i] = cfg_en; m_lvl[i] = cfg_lvl;
        end
        m_prev[i] = evt[i];
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int top;
    int act_exp;
    top = 0; act_exp = 0;
    for (int i = 0; i < N; i++) begin
      if (m_pend[i] && m_en[i] && m_lvl[i] != 0) begin
        act_exp = act_exp | (1 << i);
        if (m_lvl[i] > top) top = m_lvl[i];
      end
    end
    chk("R5 model src_active", src_active, act_exp);
    chk("R7 model irq_n", irq_n, (~top) & 7);
    chk("R9 model status", rd_status,
        (m_lvl[rd_idx] << 2) | (m_en[rd_idx] << 1) | m_pend[rd_idx]);
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cfg(input int idx, input bit en, input int lvl);
    cfg_we = 1; cfg_idx = idx[IDX_W-1:0]; cfg_en = en; cfg_lvl = lvl[1:0];
    tick();
    cfg_we = 0;
  endtask

  task automatic clr(input logic [N-1:0] m);
    clr_we = 1; clr_mask = m;
    tick();
    clr_we = 0; clr_mask = '0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    evt = m;
    tick();
    evt = '0;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    at_neg();
    chk("R1 reset irq_n", irq_n, 3'b111);
    chk("R1 reset active", src_active, 0);
    chk("R1 reset status", rd_status, 0);

    cfg(0, 1, 2);
    cfg(1, 1, 2);
    at_neg();
    chk("R5 enabled not pending", src_active, 0);

    pulse(4'b0001);
    at_neg();
    chk("R2 event sets pending", src_active, 4'b0001);
    chk("R7 level 2 code", irq_n, 3'b101);

    pulse(4'b0010);
    at_neg();
    chk("R8 two sources active", src_active, 4'b0011);

    clr(4'b0001);
    at_neg();
    chk("R8 line held by other source", irq_n, 3'b101);
    chk("R3 only masked cleared", src_active, 4'b0010);

    clr(4'b0001);
    at_neg();
    chk("R3 zero mask bit untouched", src_active, 4'b0010);

    clr(4'b0010);
    at_neg();
    chk("R8 last clear releases line", irq_n, 3'b111);

    cfg(2, 1, 3);
    pulse(4'b0101);
    at_neg();
    chk("R7 highest level wins", irq_n, 3'b100);
    chk("R7 both drive", src_active, 4'b0101);
    clr(4'b0101);
    at_neg();
    chk("R3 both cleared", irq_n, 3'b111);

    cfg(3, 1, 1);
    evt = 4'b1000; clr_we = 1; clr_mask = 4'b1000;
    tick();
    clr_we = 0; clr_mask = '0;
    at_neg();
    chk("R4 set beats clear", src_active, 4'b1000);
    chk("R4 level 1 code", irq_n, 3'b110);
    clr(4'b1000);
    at_neg();
    chk("R2 held event no repend", src_active, 0);
    tick();
    at_neg();
    chk("R2 held event still clear", irq_n, 3'b111);
    evt = '0;

    cfg(1, 0, 2);
    pulse(4'b0010);
    rd_idx = 1;
    at_neg();
    chk("R10 disabled no drive", irq_n, 3'b111);
    chk("R9 status layout", rd_status, 4'b1001);
    repeat (3) tick();
    at_neg();
    chk("R9 read no side effect", rd_status, 4'b1001);
    cfg(1, 1, 2);
    at_neg();
    chk("R10 enable drives pending", irq_n, 3'b101);

    cfg(1, 1, 0);
    at_neg();
    chk("R6 level zero no drive", irq_n, 3'b111);
    chk("R6 status level zero", rd_status, 4'b0011);
    clr(4'b0010);
    at_neg();
    chk("R3 final clear", rd_status, 4'b0010);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule